// File: doc/BRIEF.md
# Tuple-Walking Station Address Finder

This block searches a byte-wide boot ROM for the network station address. The ROM holds a chain of variable-length records. Each record opens with a four-byte header. After a start strobe the block reads header after header. It follows the forward link in each header until it meets the record that describes a six-byte address. It then copies that payload into a 48-bit output.

The ROM sits outside the block. The block drives a byte address and a read strobe. The ROM returns the byte on the data input in the cycle after the strobe. A scan ends with a one-cycle completion pulse, and a found flag tells whether an address was recovered. The found flag and the address stay unchanged until software issues the next start.

Top module: `mac_tuple_scanner`

## Requirements
- R1: After reset, `done`, `found` and `rom_rd` are low and `mac_addr` is zero.
- R2: A `start` pulse accepted while idle begins a scan. The first read strobe appears in the next cycle at byte address 0x100.
- R3: Each read strobe lasts one cycle. The byte is taken from `rom_data` in the cycle that follows it. Two read strobes are never issued in back-to-back cycles.
- R4: Header bytes are decoded by offset from the record base: +0 record code, +1 link, +2 payload identifier, +3 payload length. A record matches only when code = 0x22, identifier = 0x04 and length = 0x06. A match takes priority over the link value, so a matching record with link 0 still yields a result.
- R5: On a match, the bytes at offsets +4 to +9 form the address. The byte at +4 lands in `mac_addr[47:40]` and the byte at +9 in `mac_addr[7:0]`. `found` is then 1.
- R6: For a record that does not match, the next record base is the current base plus the link plus 2.
- R7: A record that does not match and has link 0 ends the scan with `found` = 0.
- R8: The scan ends with `found` = 0 when the next record base would be 0x1F7 or higher. A next base of 0x1F6 is still read.
- R9: `done` is high for exactly one cycle per scan, and `found` is valid in that cycle. `found` and `mac_addr` hold until the next accepted start, which clears both. When nothing is found, `mac_addr` reads zero.
- R10: A `start` pulse during a running scan is ignored. The scan neither restarts nor changes its result.
- R11: A header that agrees with the match values in only some of its three fields counts as a non-match and is skipped by its link.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to begin a scan |
| rom_rd | output | 1 | Read strobe to the ROM |
| rom_addr | output | AW | Byte address for the read |
| rom_data | input | 8 | ROM byte, valid the cycle after `rom_rd` |
| done | output | 1 | One-cycle end-of-scan pulse |
| found | output | 1 | Address recovered by the last scan |
| mac_addr | output | 8*MAC_BYTES | Recovered station address, first byte most significant |

## Verification
The bench builds the block with its default parameters: a 12-bit address bus, scan window 0x100 to 0x1F6, a six-byte payload and most-significant-first packing. With these values, a record placed at the last legal base 0x1F6 has its payload end exactly at 0x1FF. A link of 0xF5 from 0x100 lands on the first excluded address, so both sides of the window edge are tested. Because packing is most-significant-first, the byte-order requirement can be checked directly against the ROM contents.

// File: rtl/scan_pkg.sv
package scan_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_REQ,
      ST_CAP,
      ST_EVAL,
      ST_PUB
   } scan_state_t;

   typedef enum logic {
      PH_HDR,
      PH_DATA
   } scan_phase_t;
endpackage

// File: rtl/scan_hdr_match.sv
module scan_hdr_match #(
   parameter logic [7:0] CODE_V = 8'h22,
   parameter logic [7:0] ID_V   = 8'h04,
   parameter logic [7:0] LEN_V  = 8'h06
) (
   input  logic [7:0] code_b,
   input  logic [7:0] id_b,
   input  logic [7:0] len_b,
   output logic       hit
);
   // all three fields must agree; a partial agreement is a miss
   assign hit = (code_b == CODE_V) && (id_b == ID_V) && (len_b == LEN_V);
endmodule

// File: rtl/scan_next_addr.sv
module scan_next_addr #(
   parameter int AW    = 12,
   parameter int LIMIT = 'h1F7
) (
   input  logic [AW-1:0] base,
   input  logic [7:0]    link,
   output logic [AW-1:0] nxt,
   output logic          past_end
);
   // one spare bit so a sum beyond the bus width still compares correctly
   logic [AW:0] sum;

   assign sum      = {1'b0, base} + (AW+1)'(link) + (AW+1)'(2);
   assign past_end = (sum >= (AW+1)'(LIMIT));
   assign nxt      = sum[AW-1:0];
endmodule

// File: rtl/scan_byte_collect.sv
module scan_byte_collect #(
   parameter int NBYTES    = 6,
   parameter bit MSB_FIRST = 1'b1,
   parameter int IW        = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clr,
   input  logic                load,
   input  logic [7:0]          din,
   input  logic [IW-1:0]       pos,
   output logic [8*NBYTES-1:0] q
);
   localparam int W = 8 * NBYTES;

   generate
      if (MSB_FIRST) begin : g_shift
         // first byte read ends up in the top byte lane
         logic unused_pos;
         assign unused_pos = ^pos;
         always_ff @(posedge clk) begin
            if (!rst_n || clr) q <= '0;
            else if (load)     q <= W'({q, din});
         end
      end else begin : g_place
         // first byte read lands in the bottom byte lane
         always_ff @(posedge clk) begin
            if (!rst_n || clr) q <= '0;
            else if (load)     q[int'(pos)*8 +: 8] <= din;
         end
      end
   endgenerate
endmodule

// File: rtl/mac_tuple_scanner.sv
module mac_tuple_scanner
   import scan_pkg::*;
#(
   parameter int         AW         = 12,
   parameter int         START_ADDR = 'h100,
   parameter int         LIMIT_ADDR = 'h1F7,
   parameter logic [7:0] MATCH_CODE = 8'h22,
   parameter logic [7:0] MATCH_ID   = 8'h04,
   parameter logic [7:0] MATCH_LEN  = 8'h06,
   parameter int         MAC_BYTES  = 6,
   parameter bit         MSB_FIRST  = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   start,
   output logic                   rom_rd,
   output logic [AW-1:0]          rom_addr,
   input  logic [7:0]             rom_data,
   output logic                   done,
   output logic                   found,
   output logic [8*MAC_BYTES-1:0] mac_addr
);
   localparam int HDR_BYTES = 4;
   localparam int LAST_IDX  = HDR_BYTES + MAC_BYTES - 1;
   localparam int IDXW      = $clog2(LAST_IDX + 1);
   localparam int CIW       = (MAC_BYTES > 1) ? $clog2(MAC_BYTES) : 1;
   localparam int MACW      = 8 * MAC_BYTES;

   // elaboration-time parameter checks
   if (AW < 9 || AW <= IDXW) begin : g_bad_aw
      $error("AW too narrow for link arithmetic");
   end
   if (START_ADDR >= LIMIT_ADDR) begin : g_bad_window
      $error("START_ADDR must lie below LIMIT_ADDR");
   end
   if (LIMIT_ADDR + LAST_IDX > (1 << AW)) begin : g_bad_reach
      $error("last record payload does not fit the address bus");
   end
   if (MAC_BYTES < 1) begin : g_bad_bytes
      $error("MAC_BYTES must be at least 1");
   end

   scan_state_t     st;
   scan_phase_t     ph;
   logic [AW-1:0]   base;
   logic [IDXW-1:0] idx;
   logic [7:0]      h_code, h_link, h_id, h_len;
   logic            found_q, done_q;
   logic [MACW-1:0] mac_q, coll_q;
   logic            hit, past_end;
   logic [AW-1:0]   nxt;
   logic            busy;
   logic            coll_clr, coll_ld;
   logic [CIW-1:0]  coll_pos;

   assign busy     = (st != ST_IDLE);
   assign rom_rd   = (st == ST_REQ);
   assign rom_addr = base + AW'(idx);
   assign done     = done_q;
   assign found    = found_q;
   assign mac_addr = mac_q;

   assign coll_clr = (st == ST_IDLE) && start;
   assign coll_ld  = (st == ST_CAP) && (ph == PH_DATA);
   assign coll_pos = CIW'(idx - IDXW'(HDR_BYTES));

   scan_hdr_match #(
      .CODE_V (MATCH_CODE),
      .ID_V   (MATCH_ID),
      .LEN_V  (MATCH_LEN)
   ) u_match (
      .code_b (h_code),
      .id_b   (h_id),
      .len_b  (h_len),
      .hit    (hit)
   );

   scan_next_addr #(
      .AW    (AW),
      .LIMIT (LIMIT_ADDR)
   ) u_next (
      .base     (base),
      .link     (h_link),
      .nxt      (nxt),
      .past_end (past_end)
   );

   scan_byte_collect #(
      .NBYTES    (MAC_BYTES),
      .MSB_FIRST (MSB_FIRST),
      .IW        (CIW)
   ) u_coll (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (coll_clr),
      .load  (coll_ld),
      .din   (rom_data),
      .pos   (coll_pos),
      .q     (coll_q)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         ph      <= PH_HDR;
         base    <= '0;
         idx     <= '0;
         h_code  <= '0;
         h_link  <= '0;
         h_id    <= '0;
         h_len   <= '0;
         found_q <= 1'b0;
         done_q  <= 1'b0;
         mac_q   <= '0;
      end else begin
         done_q <= 1'b0;
         case (st)
            ST_IDLE: begin
               if (start) begin
                  base    <= AW'(START_ADDR);
                  idx     <= '0;
                  ph      <= PH_HDR;
                  found_q <= 1'b0;
                  mac_q   <= '0;
                  st      <= ST_REQ;
               end
            end
            ST_REQ: st <= ST_CAP;
            ST_CAP: begin
               if (ph == PH_HDR) begin
                  case (idx[1:0])
                     2'd0:    h_code <= rom_data;
                     2'd1:    h_link <= rom_data;
                     2'd2:    h_id   <= rom_data;
                     default: h_len  <= rom_data;
                  endcase
                  if (idx == IDXW'(HDR_BYTES - 1)) begin
                     st <= ST_EVAL;
                  end else begin
                     idx <= idx + 1'b1;
                     st  <= ST_REQ;
                  end
               end else if (idx == IDXW'(LAST_IDX)) begin
                  st <= ST_PUB;
               end else begin
                  idx <= idx + 1'b1;
                  st  <= ST_REQ;
               end
            end
            ST_EVAL: begin
               if (hit) begin
                  ph  <= PH_DATA;
                  idx <= IDXW'(HDR_BYTES);
                  st  <= ST_REQ;
               end else if (h_link == 8'h00 || past_end) begin
                  done_q <= 1'b1;
                  st     <= ST_IDLE;
               end else begin
                  base <= nxt;
                  idx  <= '0;
                  st   <= ST_REQ;
               end
            end
            ST_PUB: begin
               mac_q   <= coll_q;
               found_q <= 1'b1;
               done_q  <= 1'b1;
               st      <= ST_IDLE;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/scan_checker.sv
module scan_checker #(
   parameter int AW         = 12,
   parameter int MACW       = 48,
   parameter int START_ADDR = 'h100
) (
   input logic            clk,
   input logic            rst_n,
   input logic            start,
   input logic            rom_rd,
   input logic [AW-1:0]   rom_addr,
   input logic            done,
   input logic            found,
   input logic [MACW-1:0] mac_addr,
   input logic            busy
);
   a_r3_read_spacing: assert property (@(posedge clk) disable iff (!rst_n)
      rom_rd |=> !rom_rd);

   a_r2_addr_floor: assert property (@(posedge clk) disable iff (!rst_n)
      rom_rd |-> (rom_addr >= AW'(START_ADDR)));

   a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   a_r9_found_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> (done || $stable(found)));

   a_r9_mac_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> (done || $stable(mac_addr)));

   a_r9_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !found) |-> (mac_addr == '0));
endmodule

bind mac_tuple_scanner scan_checker #(
   .AW         (AW),
   .MACW       (8 * MAC_BYTES),
   .START_ADDR (START_ADDR)
) u_scan_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .start    (start),
   .rom_rd   (rom_rd),
   .rom_addr (rom_addr),
   .done     (done),
   .found    (found),
   .mac_addr (mac_addr),
   .busy     (busy)
);

// File: tb/mac_tuple_scanner_tb_top.sv
`timescale 1ns/1ps
module mac_tuple_scanner_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        rom_rd;
   logic [11:0] rom_addr;
   logic [7:0]  rom_data;
   logic        done;
   logic        found;
   logic [47:0] mac_addr;

   int n_chk = 0;
   int n_fail = 0;
   int last_base = 0;

   always #10 clk = ~clk;   // 50 MHz

   mac_tuple_scanner dut_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .rom_rd   (rom_rd),
      .rom_addr (rom_addr),
      .rom_data (rom_data),
      .done     (done),
      .found    (found),
      .mac_addr (mac_addr)
   );

   // ROM model: one cycle read latency
   logic [7:0] rom [0:4095];
   logic [7:0] rom_q;
   always_ff @(posedge clk) if (rom_rd) rom_q <= rom[rom_addr];
   assign rom_data = rom_q;

   // read monitor
   int          total_rd = 0;
   int          b2b = 0;
   logic        prev_rd = 1'b0;
   logic [11:0] rd_log [0:255];
   always @(posedge clk) begin
      if (rst_n && rom_rd) begin
         rd_log[total_rd % 256] <= rom_addr;
         total_rd <= total_rd + 1;
         if (prev_rd) b2b <= b2b + 1;
      end
      prev_rd <= rom_rd;
   end

   // watchdog
   initial begin
      repeat (150000) @(posedge clk);
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk + 1, n_fail + 1);
      $finish;
   end

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic clear_rom();
      for (int i = 0; i < 4096; i++) rom[i] = 8'h00;
   endtask

   task automatic put_tuple(input int a, input logic [7:0] code, input logic [7:0] link,
                            input logic [7:0] id, input logic [7:0] len, input logic [47:0] pay);
      rom[a]     = code;
      rom[a + 1] = link;
      rom[a + 2] = id;
      rom[a + 3] = len;
      for (int k = 0; k < 6; k++) rom[a + 4 + k] = pay[47 - 8*k -: 8];
   endtask

   task automatic run_scan(input int again_at, output bit f, output logic [47:0] m, output int nrd);
      bit seen = 1'b0;
      last_base = total_rd;
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
      for (int i = 1; i < 3000; i++) begin
         if (done) begin seen = 1'b1; break; end
         start = (i == again_at);
         @(negedge clk);
      end
      start = 1'b0;
      chk(seen, "R9 scan completion", 64'(seen), 64'd1);
      f = found;
      m = mac_addr;
      nrd = total_rd - last_base;
      @(negedge clk);
      chk(done == 1'b0, "R9 done width one cycle", 64'(done), 64'd0);
   endtask

   function automatic int reads_of(input int addr);
      int c = 0;
      for (int i = last_base; i < total_rd; i++) if (int'(rd_log[i % 256]) == addr) c++;
      return c;
   endfunction

   task automatic t_reset();
      chk(done == 1'b0,   "R1 done at reset",   64'(done),   64'd0);
      chk(found == 1'b0,  "R1 found at reset",  64'(found),  64'd0);
      chk(rom_rd == 1'b0, "R1 rom_rd at reset", 64'(rom_rd), 64'd0);
      chk(mac_addr == 0,  "R1 mac at reset",    64'(mac_addr), 64'd0);
   endtask

   task automatic t_direct();
      bit f; logic [47:0] m; int n;
      clear_rom();
      put_tuple('h100, 8'h22, 8'h00, 8'h04, 8'h06, 48'hA1B2C3D4E5F6);
      run_scan(0, f, m, n);
      chk(int'(rd_log[last_base % 256]) == 'h100, "R2 first read address",
          64'(rd_log[last_base % 256]), 64'h100);
      chk(f == 1'b1, "R4 match with link zero", 64'(f), 64'd1);
      chk(m == 48'hA1B2C3D4E5F6, "R5 byte order", 64'(m), 64'hA1B2C3D4E5F6);
      chk(n == 10, "R5 read count", 64'(n), 64'd10);
   endtask

   task automatic t_chain();
      bit f; logic [47:0] m; int n;
      clear_rom();
      put_tuple('h100, 8'h01, 8'h08, 8'h04, 8'h06, 48'hFFFFFFFFFFFF);
      put_tuple('h10A, 8'h22, 8'h30, 8'h04, 8'h06, 48'h0123456789AB);
      run_scan(0, f, m, n);
      chk(int'(rd_log[(last_base + 4) % 256]) == 'h10A, "R6 next base",
          64'(rd_log[(last_base + 4) % 256]), 64'h10A);
      chk(f == 1'b1 && m == 48'h0123456789AB, "R6 chained result", 64'(m), 64'h0123456789AB);
   endtask

   task automatic t_partial();
      bit f; logic [47:0] m; int n;
      clear_rom();
      put_tuple('h100, 8'h22, 8'h03, 8'h05, 8'h06, 48'h0);
      put_tuple('h105, 8'h22, 8'h02, 8'h04, 8'h07, 48'h0);
      put_tuple('h109, 8'h22, 8'h00, 8'h04, 8'h06, 48'h112233445566);
      run_scan(0, f, m, n);
      chk(n == 18, "R11 partial headers skipped", 64'(n), 64'd18);
      chk(f == 1'b1 && m == 48'h112233445566, "R11 result after partials", 64'(m), 64'h112233445566);
   endtask

   task automatic t_link_zero();
      bit f; logic [47:0] m; int n;
      clear_rom();
      put_tuple('h100, 8'h10, 8'h00, 8'h04, 8'h06, 48'h0);
      run_scan(0, f, m, n);
      chk(f == 1'b0, "R7 link zero miss", 64'(f), 64'd0);
      chk(n == 4, "R7 stop after one header", 64'(n), 64'd4);
      chk(m == 48'h0, "R9 mac zero on miss", 64'(m), 64'd0);
   endtask

   task automatic t_limit_stop();
      bit f; logic [47:0] m; int n;
      clear_rom();
      put_tuple('h100, 8'h01, 8'hF5, 8'h00, 8'h00, 48'h0);
      put_tuple('h1F7, 8'h22, 8'h00, 8'h04, 8'h06, 48'h777777777777);
      run_scan(0, f, m, n);
      chk(f == 1'b0, "R8 base 0x1F7 excluded", 64'(f), 64'd0);
      chk(n == 4, "R8 no read past window", 64'(n), 64'd4);
   endtask

   task automatic t_limit_edge();
      bit f; logic [47:0] m; int n;
      clear_rom();
      put_tuple('h100, 8'h01, 8'hF4, 8'h00, 8'h00, 48'h0);
      put_tuple('h1F6, 8'h22, 8'h00, 8'h04, 8'h06, 48'hCAFEF00D1234);
      run_scan(0, f, m, n);
      chk(int'(rd_log[(last_base + 4) % 256]) == 'h1F6, "R8 base 0x1F6 read",
          64'(rd_log[(last_base + 4) % 256]), 64'h1F6);
      chk(f == 1'b1 && m == 48'hCAFEF00D1234, "R8 edge record found", 64'(m), 64'hCAFEF00D1234);
   endtask

   task automatic t_hold();
      bit f; logic [47:0] m; int n; bit ok = 1'b1;
      clear_rom();
      put_tuple('h100, 8'h22, 8'h00, 8'h04, 8'h06, 48'h5A5A12345678);
      run_scan(0, f, m, n);
      for (int i = 0; i < 20; i++) begin
         if (found != 1'b1 || mac_addr != 48'h5A5A12345678 || done) ok = 1'b0;
         @(negedge clk);
      end
      chk(ok, "R9 result held while idle", 64'(mac_addr), 64'h5A5A12345678);
   endtask

   task automatic t_busy_start();
      bit f; logic [47:0] m; int n;
      clear_rom();
      put_tuple('h100, 8'h05, 8'h20, 8'h00, 8'h00, 48'h0);
      put_tuple('h122, 8'h22, 8'h00, 8'h04, 8'h06, 48'h665544332211);
      run_scan(3, f, m, n);
      chk(reads_of('h100) == 1, "R10 no restart", 64'(reads_of('h100)), 64'd1);
      chk(f == 1'b1 && m == 48'h665544332211, "R10 result intact", 64'(m), 64'h665544332211);
   endtask

   initial begin
      clear_rom();
      repeat (4) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_direct();
      t_chain();
      t_partial();
      t_link_zero();
      t_limit_stop();
      t_limit_edge();
      t_hold();
      t_busy_start();
      chk(b2b == 0, "R3 read strobes spaced", 64'(b2b), 64'd0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule